// File: doc/BRIEF.md
# Banked General-Purpose I/O Controller with Interrupt Detection

This block is a register-mapped pin controller for a parameterised number of general-purpose pins (94 by default). A host reaches it over a simple synchronous bus: one access per strobe, a byte address and 32-bit data. Every pin owns two configuration words. The first holds the pin's mode, direction, output level and trigger type, and shows the sampled input level. The second holds the input-sense disable bit and a two-bit pull selection, which is driven out to the pad ring.

Three bitmap registers are shared by all pins. Each is a run of consecutive 32-bit words, and each word covers 32 pins. The bitmaps hold the firmware ownership bits, the latched interrupt status and the interrupt enables. Pin inputs pass through a synchroniser, then through per-pin trigger logic that can detect an edge of either polarity or a level of either polarity. Detected events set a status bit, which software clears by writing ones. A single interrupt output combines every status bit whose enable bit is set.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset:
  - every ownership bit of an existing pin reads 1, and bits above the last pin read 0 (word at 0x08 reads 0x3FFFFFFF with 94 pins);
  - all status and enable bits read 0;
  - every first configuration word reads 0x00000005 (GPIO use, input) and every second word reads 0x00000004 (sensing off);
  - `irq` and all of `pin_oe` are low.
- R2: The three bitmaps are based at 0x00 (ownership), 0x80 (status) and 0x90 (enable). Pin p is bit p%32 of the word at base + 4*(p/32).
- R3: The first configuration word of pin n is at 0x100 + 8n and the second at 0x104 + 8n. In the first word:
  - bit 31 is the output level;
  - bit 30 is the read-only input level;
  - bit 4 is the level select;
  - bit 3 is the polarity invert;
  - bit 2 is the direction (1 = input);
  - bit 0 is the use select (1 = GPIO).
  Every other bit reads 0, and so do unmapped addresses. Read data appears on `bus_rdata` in the cycle after the read strobe.
- R4: Bit 30 of the first word shows the pin input after a two-flop synchroniser while sensing is enabled, and reads 0 while sensing is disabled.
- R5: `pin_oe[n]` is high only when the pin is in GPIO use, its direction bit is 0 (output) and its ownership bit is 1. `pin_out[n]` follows bit 31.
- R6: Trigger type is taken from bits {4,3}: 00 rising edge, 01 falling edge, 10 level low, 11 level high. An edge of the wrong polarity sets no status. Events are detected only while the pin is in GPIO use with sensing enabled.
- R7: While a level condition holds, its status bit sets again on the cycle after a clear.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: An event that arrives in the same cycle as the clear of its status bit leaves the bit set.
- R10: `irq` is high exactly when some status bit is set together with its enable bit. A status bit whose enable is 0 does not raise `irq`.
- R11: In the second word, bit 2 disables input sensing and bits 1:0 drive `pull_sel[2n+1:2n]`.
- R12: A 32-bit global control word at 0x7C reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address, low two bits ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_in | input | NUM_PINS (94) | Asynchronous pin input levels |
| pin_out | output | NUM_PINS (94) | Output level per pin |
| pin_oe | output | NUM_PINS (94) | Output enable per pin |
| pull_sel | output | 2*NUM_PINS (188) | Pull option per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: 94 pins, a 12-bit address and two synchroniser stages. With 94 pins the last bitmap word is only partly filled, so the bench can check that pins 32, 64 and 93 land at word boundaries and that the unused high bits of the last word read 0. With two synchroniser stages the bench can place a status clear on the exact cycle a fresh edge is detected, and confirm that the event survives the clear.

// File: rtl/gpio_bank_pkg.sv
// Shared constants for the banked pin controller.
// Assumes: bitmap bases are 16-byte aligned and hold at most four words each.
package gpio_bank_pkg;

    // Bitmap register bases
    localparam int OWN_BASE  = 'h00;
    localparam int GCTL_OFF  = 'h7C;
    localparam int STAT_BASE = 'h80;
    localparam int EN_BASE   = 'h90;
    localparam int CFG_BASE  = 'h100;

    // First configuration word bit positions
    localparam int B_OUT  = 31;
    localparam int B_INL  = 30;
    localparam int B_LVL  = 4;
    localparam int B_INV  = 3;
    localparam int B_DIR  = 2;
    localparam int B_USE  = 0;

    // Second configuration word bit positions
    localparam int B_NOSENSE = 2;

    // Trigger kinds selected by {level select, invert}
    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_e;

endpackage

// File: rtl/gpio_bank_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes: each bit is independent; no bus coherency is needed across bits.
module gpio_bank_sync #(
    parameter int W      = 94,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // Shift the inputs through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_bank_pin.sv
// One pin slice: both configuration words, ownership, enable and status
// bits, the trigger detector and the pad-side drive.
// Assumes: sync_in is already synchronised to clk.
module gpio_bank_pin
    import gpio_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sync_in,
    input  logic [31:0] wdata,
    input  logic        cfg1_we,
    input  logic        cfg2_we,
    input  logic        own_we,
    input  logic        own_wbit,
    input  logic        en_we,
    input  logic        en_wbit,
    input  logic        clr,
    output logic [31:0] cfg1_rd,
    output logic [31:0] cfg2_rd,
    output logic        own,
    output logic        en,
    output logic        stat,
    output logic        pin_out,
    output logic        pin_oe,
    output logic [1:0]  pull
);

    logic  out_lvl, lvl_sel, inv_sel, dir_in, use_gpio, no_sense;
    logic  prev;
    logic  armed, cond, event_w, sensed;
    trig_e kind;

    // First configuration word: mode, direction, output level, trigger type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_lvl  <= 1'b0;
            lvl_sel  <= 1'b0;
            inv_sel  <= 1'b0;
            dir_in   <= 1'b1;
            use_gpio <= 1'b1;
        end else if (cfg1_we) begin
            out_lvl  <= wdata[B_OUT];
            lvl_sel  <= wdata[B_LVL];
            inv_sel  <= wdata[B_INV];
            dir_in   <= wdata[B_DIR];
            use_gpio <= wdata[B_USE];
        end
    end

    // Second configuration word: sense disable and pull option.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            no_sense <= 1'b1;
            pull     <= 2'b00;
        end else if (cfg2_we) begin
            no_sense <= wdata[B_NOSENSE];
            pull     <= wdata[1:0];
        end
    end

    // Ownership and enable bits from the shared bitmaps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own <= 1'b1;
            en  <= 1'b0;
        end else begin
            if (own_we) own <= own_wbit;
            if (en_we)  en  <= en_wbit;
        end
    end

    // Previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sync_in;
    end

    assign kind   = trig_e'({lvl_sel, inv_sel});
    assign armed  = use_gpio & ~no_sense;
    assign sensed = sync_in & ~no_sense;

    // Decode the trigger condition for the selected kind.
    always_comb begin
        unique case (kind)
            TRIG_RISE: cond = sync_in & ~prev;
            TRIG_FALL: cond = ~sync_in & prev;
            TRIG_LOW:  cond = ~sync_in;
            TRIG_HIGH: cond = sync_in;
            default:   cond = 1'b0;
        endcase
    end

    assign event_w = armed & cond;

    // Status bit: a clear never wins against a new event.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= 1'b0;
        else        stat <= (stat & ~clr) | event_w;
    end

    assign cfg1_rd = {out_lvl, sensed, 25'b0, lvl_sel, inv_sel, dir_in, 1'b0, use_gpio};
    assign cfg2_rd = {29'b0, no_sense, pull};
    assign pin_out = out_lvl;
    assign pin_oe  = use_gpio & ~dir_in & own;

    // R9: an event in the clear cycle is kept
    a_r9_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        event_w |=> stat);

    // R8: a clear with no event empties the bit
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !event_w) |=> !stat);

    // R8: without a clear, a set bit stays set
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat && !clr) |=> stat);

    // R7: a held level condition always leaves the bit set
    a_r7_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (use_gpio && !no_sense && lvl_sel && (sync_in == inv_sel)) |=> stat);

    // R6: nothing sets the bit while the pin is not armed
    a_r6_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat && !armed) |=> !stat);

endmodule

// File: rtl/gpio_bank_ctrl.sv
// Banked pin controller top: bus decode, read multiplexer, synchroniser,
// a generated array of pin slices and the combined interrupt.
// Assumes: word-aligned accesses, NUM_PINS <= 128, CFG space fits in ADDR_W.
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS    = 94,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [2*NUM_PINS-1:0] pull_sel,
    output logic                  irq
);

    localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int FLAT_W    = NUM_WORDS * 32;
    localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + 8 * NUM_PINS);
    localparam logic [ADDR_W-5:0] BLK_OWN  = (ADDR_W-4)'(OWN_BASE >> 4);
    localparam logic [ADDR_W-5:0] BLK_STAT = (ADDR_W-4)'(STAT_BASE >> 4);
    localparam logic [ADDR_W-5:0] BLK_EN   = (ADDR_W-4)'(EN_BASE >> 4);
    localparam logic [ADDR_W-3:0] W_GCTL   = (ADDR_W-2)'(GCTL_OFF >> 2);

    logic                wr, rd;
    logic [WIDX_W-1:0]   word_idx;
    logic                word_ok;
    logic                hit_own, hit_stat, hit_en, hit_gctl, hit_cfg;
    logic [ADDR_W-1:0]   cfg_off;
    logic [PIN_W-1:0]    pin_sel;
    logic [NUM_PINS-1:0] sync_q;
    logic [FLAT_W-1:0]   own_flat, stat_flat, en_flat;
    logic [31:0]         cfg1_arr [NUM_PINS];
    logic [31:0]         cfg2_arr [NUM_PINS];
    logic [31:0]         gctl_q;
    logic [31:0]         rd_mux;

    assign wr = bus_sel & bus_wr;
    assign rd = bus_sel & ~bus_wr;

    // Address decode for bitmaps, global word and per-pin space.
    assign word_idx = bus_addr[2 +: WIDX_W];
    assign word_ok  = int'(word_idx) < NUM_WORDS;
    assign hit_own  = (bus_addr[ADDR_W-1:4] == BLK_OWN)  && word_ok;
    assign hit_stat = (bus_addr[ADDR_W-1:4] == BLK_STAT) && word_ok;
    assign hit_en   = (bus_addr[ADDR_W-1:4] == BLK_EN)   && word_ok;
    assign hit_gctl = (bus_addr[ADDR_W-1:2] == W_GCTL);
    assign hit_cfg  = (bus_addr >= CFG_LO) && (bus_addr < CFG_HI);
    assign cfg_off  = bus_addr - CFG_LO;
    assign pin_sel  = cfg_off[3 +: PIN_W];

    gpio_bank_sync #(
        .W      (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_q)
    );

    // One slice per pin with its decoded strobes.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int WI = p / 32;
        localparam int BI = p % 32;
        logic word_hit;
        assign word_hit = (word_idx == WIDX_W'(WI));

        gpio_bank_pin u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_in  (sync_q[p]),
            .wdata    (bus_wdata),
            .cfg1_we  (wr && hit_cfg && (pin_sel == PIN_W'(p)) && !bus_addr[2]),
            .cfg2_we  (wr && hit_cfg && (pin_sel == PIN_W'(p)) &&  bus_addr[2]),
            .own_we   (wr && hit_own && word_hit),
            .own_wbit (bus_wdata[BI]),
            .en_we    (wr && hit_en && word_hit),
            .en_wbit  (bus_wdata[BI]),
            .clr      (wr && hit_stat && word_hit && bus_wdata[BI]),
            .cfg1_rd  (cfg1_arr[p]),
            .cfg2_rd  (cfg2_arr[p]),
            .own      (own_flat[p]),
            .en       (en_flat[p]),
            .stat     (stat_flat[p]),
            .pin_out  (pin_out[p]),
            .pin_oe   (pin_oe[p]),
            .pull     (pull_sel[2*p +: 2])
        );
    end

    // Bits past the last pin read as zero.
    for (genvar q = NUM_PINS; q < FLAT_W; q++) begin : g_pad
        assign own_flat[q]  = 1'b0;
        assign en_flat[q]   = 1'b0;
        assign stat_flat[q] = 1'b0;
    end

    // Global control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                gctl_q <= '0;
        else if (wr && hit_gctl)   gctl_q <= bus_wdata;
    end

    // Select the addressed word for a read.
    always_comb begin
        rd_mux = '0;
        if (hit_own)       rd_mux = own_flat[int'(word_idx)*32 +: 32];
        else if (hit_stat) rd_mux = stat_flat[int'(word_idx)*32 +: 32];
        else if (hit_en)   rd_mux = en_flat[int'(word_idx)*32 +: 32];
        else if (hit_gctl) rd_mux = gctl_q;
        else if (hit_cfg)  rd_mux = bus_addr[2] ? cfg2_arr[pin_sel] : cfg1_arr[pin_sel];
    end

    // Register read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd ? rd_mux : '0;
    end

    assign irq = |(stat_flat & en_flat);

    // R10: with every enable bit clear the interrupt stays low
    a_r10_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (en_flat == '0) |-> !irq);

    // R3: an idle or write cycle leaves zero on the read bus next cycle
    a_r3_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (bus_rdata == '0));

endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;

    localparam int NP = 94;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic [2*NP-1:0] pull_sel;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    gpio_bank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pull_sel(pull_sel), .irq(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop the expected item for each read issued at this edge.
    always @(posedge clk) begin
        logic issued;
        issued = bus_sel & ~bus_wr;
        #2;
        if (issued) begin
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk({31'b0, irq}, 0, "R1 irq after reset");
        chk({31'b0, |pin_oe}, 0, "R1 pin_oe after reset");
        rd(12'h000, 32'hFFFF_FFFF, "R1 ownership word0");
        rd(12'h008, 32'h3FFF_FFFF, "R1 R2 ownership last word");
        rd(12'h080, 32'h0, "R1 status word0");
        rd(12'h098, 32'h0, "R1 enable word2");
        rd(12'h100, 32'h5, "R1 cfg1 pin0");
        rd(12'h3EC, 32'h4, "R1 cfg2 pin93");
        rd(12'h3F0, 32'h0, "R3 unmapped past last pin");

        // R12 global control word
        wr(12'h07C, 32'hA5A5_0F0F);
        rd(12'h07C, 32'hA5A5_0F0F, "R12 global word readback");

        // R3 writable fields of the first word
        wr(12'h128, 32'hFFFF_FFFF);
        rd(12'h128, 32'h8000_001D, "R3 cfg1 field mask pin5");

        // R5 output drive and its qualifiers
        chk({31'b0, pin_oe[5]}, 0, "R5 input direction no oe");
        wr(12'h128, 32'h8000_0001);
        chk({30'b0, pin_oe[5], pin_out[5]}, 32'h3, "R5 output drive pin5");
        wr(12'h000, 32'hFFFF_FFDF);
        chk({31'b0, pin_oe[5]}, 0, "R5 not owned no oe");
        rd(12'h000, 32'hFFFF_FFDF, "R2 ownership bit5 cleared");
        wr(12'h000, 32'hFFFF_FFFF);
        wr(12'h128, 32'h8000_0000);
        chk({31'b0, pin_oe[5]}, 0, "R5 native use no oe");

        // R4 R11 input sensing and pull select on pin 40
        pin_in[40] = 1'b1;
        idle(4);
        rd(12'h240, 32'h0000_0005, "R4 sensing off reads 0");
        wr(12'h244, 32'h1);
        chk({30'b0, pull_sel[81:80]}, 32'h1, "R11 pull select pin40");
        idle(3);
        rd(12'h240, 32'h4000_0005, "R4 sensed level pin40");
        wr(12'h244, 32'h5);
        rd(12'h240, 32'h0000_0005, "R4 R11 sense disabled again");

        // R6 rising edge on pin 33, R8 write-one-to-clear, R10 irq
        wr(12'h20C, 32'h0);
        wr(12'h094, 32'h2);
        pin_in[33] = 1'b1;
        idle(4);
        rd(12'h084, 32'h2, "R6 rising edge pin33");
        chk({31'b0, irq}, 1, "R10 irq with enable");
        wr(12'h084, 32'h0);
        rd(12'h084, 32'h2, "R8 write zero no effect");
        wr(12'h084, 32'h2);
        rd(12'h084, 32'h0, "R8 write one clears");
        chk({31'b0, irq}, 0, "R10 irq drops after clear");
        pin_in[33] = 1'b0;
        idle(4);
        rd(12'h084, 32'h0, "R6 falling ignored on rising pin");

        // R6 falling edge on pin 0
        pin_in[0] = 1'b1;
        idle(4);
        wr(12'h100, 32'hD);
        wr(12'h104, 32'h0);
        idle(3);
        rd(12'h080, 32'h0, "R6 no event while high");
        pin_in[0] = 1'b0;
        idle(4);
        rd(12'h080, 32'h1, "R6 falling edge pin0");
        wr(12'h080, 32'h1);
        rd(12'h080, 32'h0, "R8 clear pin0");

        // R7 level high on pin 93 (word 2 bit 29)
        wr(12'h3E8, 32'h1D);
        wr(12'h3EC, 32'h0);
        idle(3);
        rd(12'h088, 32'h0, "R7 level high idle");
        pin_in[93] = 1'b1;
        idle(4);
        rd(12'h088, 32'h2000_0000, "R2 R7 level high pin93");
        wr(12'h088, 32'h2000_0000);
        rd(12'h088, 32'h2000_0000, "R7 re-set after clear");
        wr(12'h098, 32'h2000_0000);
        chk({31'b0, irq}, 1, "R10 irq pin93");
        pin_in[93] = 1'b0;
        idle(4);
        wr(12'h088, 32'h2000_0000);
        rd(12'h088, 32'h0, "R7 cleared after level drop");
        chk({31'b0, irq}, 0, "R10 irq low pin93");

        // R6 level low on pin 64, R10 masking
        wr(12'h304, 32'h0);
        wr(12'h300, 32'h15);
        idle(2);
        rd(12'h088, 32'h1, "R6 level low pin64");
        chk({31'b0, irq}, 0, "R10 status without enable");
        wr(12'h098, 32'h2000_0001);
        chk({31'b0, irq}, 1, "R10 enable raises irq");
        pin_in[64] = 1'b1;
        idle(4);
        wr(12'h088, 32'h1);
        rd(12'h088, 32'h0, "R7 level low gone");

        // R9 event arriving in the clear cycle on pin 33
        pin_in[33] = 1'b1; idle(4);
        pin_in[33] = 1'b0; idle(4);
        rd(12'h084, 32'h2, "R9 status set before test");
        @(negedge clk); pin_in[33] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h084; bus_wdata = 32'h2;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(12'h084, 32'h2, "R9 edge kept during clear");
        wr(12'h084, 32'h2);
        rd(12'h084, 32'h0, "R9 later clear works");

        idle(3);
        chk(exp_q.size(), 0, "scoreboard drained");
        finish_run();
    end

endmodule